// File: doc/BRIEF.md
# Configurable Logic Slice with Carry and Wide-Function Muxes

This block models one programmable logic slice as a synthesizable circuit. It has two halves. Each half holds a 4-input lookup table whose behaviour is set by a 16-bit truth-table mask. Each half also has a one-bit ripple-carry stage, so the slice can work either as two independent logic functions or as two bits of an adder. A multiplexer steered by a select input merges the two table outputs into a 5-input function. A second multiplexer, fed by two cascade inputs from outside, forms a 6-input or wider function.

Each half drives an unregistered output and a registered output. The two registers share the clock, the clock enable and a synchronous set/reset strobe. The value the strobe loads is chosen per half. Per half, configuration also chooses what the register captures: the table output, the sum bit, or the 5-input mux output. Configuration is written one half at a time through a parallel load port.

The parameter `HAS_CARRY_REGS` builds the slice without carry and without registers, for the slice position that has neither. In that build the carry-out and the registered outputs are held at zero, and the unregistered outputs always show the table value.

Top module: `logic_slice`

## Requirements
- R1: With the half's sum-select bit clear, `f_out[h]` equals bit `{in_d[h],in_c[h],in_b[h],in_a[h]}` of that half's 16-bit mask, so `in_d` is the most significant index bit.
- R2: A rising clock edge with `cfg_we` high writes `cfg_mask`, `cfg_fsum`, `cfg_dsrc` and `cfg_lsr_set` into the half that `cfg_half` selects (0 = lower, 1 = upper). The other half is left unchanged, and with `cfg_we` low both halves hold their configuration.
- R3: With the half's sum-select bit set, `f_out[h]` equals `in_a[h] ^ in_b[h] ^ cin[h]`. Here `cin[0]` is `fci` and `cin[1]` is the majority of `in_a[0]`, `in_b[0]` and `fci`.
- R4: `fco` is the majority of `in_a[1]`, `in_b[1]` and `cin[1]`.
- R5: `ofx0` equals the upper table output when `sel_m0` is 1 and the lower table output when it is 0. It uses the raw table values whatever the sum-select bits are.
- R6: `ofx1` equals `cas_fxb` when `sel_m1` is 1 and `cas_fxa` when it is 0.
- R7: With `lsr` low and `ce` high, a rising edge loads `q_out[h]` from the source that `cfg_dsrc` names for that half: 0 = table output, 1 = sum bit, 2 = `ofx0`, 3 = table output. With `lsr` and `ce` both low, `q_out` holds its value.
- R8: `lsr` is synchronous and active high, and it overrides `ce` at either `ce` level. A rising edge with `lsr` high loads each `q_out[h]` with that half's `cfg_lsr_set` bit (1 = set, 0 = clear).
- R9: A rising edge with `rst_n` low clears both registers and all configuration (masks zero, sum-select off, source 0, strobe value 0).
- R10: With `HAS_CARRY_REGS` = 0, `fco` and `q_out` stay 0 and `f_out[h]` is the table output even when the sum-select bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and configuration |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_half | input | 1 | Half selected for a configuration write |
| cfg_mask | input | 16 | Truth-table mask to load |
| cfg_fsum | input | 1 | Sum-select bit to load (f output shows the sum) |
| cfg_dsrc | input | 2 | Register source code to load |
| cfg_lsr_set | input | 1 | Value the strobe forces into the register |
| in_a | input | 2 | Table input A, bit h for half h |
| in_b | input | 2 | Table input B, bit h for half h |
| in_c | input | 2 | Table input C, bit h for half h |
| in_d | input | 2 | Table input D, bit h for half h |
| sel_m0 | input | 1 | Select for the 5-input mux |
| sel_m1 | input | 1 | Select for the cascade mux |
| cas_fxa | input | 1 | Cascade input chosen when `sel_m1` is 0 |
| cas_fxb | input | 1 | Cascade input chosen when `sel_m1` is 1 |
| ce | input | 1 | Shared register clock enable |
| lsr | input | 1 | Shared synchronous set/reset strobe |
| fci | input | 1 | Carry input from the neighbouring slice |
| f_out | output | 2 | Unregistered output per half |
| q_out | output | 2 | Registered output per half |
| ofx0 | output | 1 | 5-input mux output |
| ofx1 | output | 1 | Cascade mux output |
| fco | output | 1 | Carry output to the next slice |

## Verification
A corrupted mask bit is visible on `f_out` in the same cycle, but only for the one input index that addresses it. For that reason the whole 256-entry input space is swept against two different masks, so that no stored bit stays untested. A wrong carry shows up at once on the upper half's sum output and on `fco`, and only for input patterns in which the lower half generates or propagates a carry. A register fault, such as a wrong source, a wrong strobe value or priority, or a lost hold, first appears one edge after the stimulus, so each register step is checked on the following clock.

// File: rtl/slice_pkg.sv
// Package for the logic slice.
// Holds the shared sizes, the register-source code and the per-half
// configuration record. Assumes a two-half slice with 4-input tables.
package slice_pkg;
    localparam int LUT_K   = 4;
    localparam int MASK_W  = 1 << LUT_K;
    localparam int HALVES  = 2;
    localparam int HALF_W  = $clog2(HALVES);

    typedef enum logic [1:0] {
        DSRC_LUT  = 2'd0,
        DSRC_SUM  = 2'd1,
        DSRC_MUX5 = 2'd2,
        DSRC_ALT  = 2'd3
    } dsrc_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              fsum;
        dsrc_e             dsrc;
        logic              lsr_set;
    } half_cfg_t;
endpackage

// File: rtl/slice_cfg_store.sv
// Configuration store for the logic slice.
// Keeps one configuration record per half. A write replaces only the
// addressed record. Assumes the write strobe is synchronous to clk.
module slice_cfg_store
    import slice_pkg::*;
#(
    parameter int NUM = HALVES,
    localparam int SEL_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  half_cfg_t  wr_word,
    output half_cfg_t  cfg_q [NUM]
);
    for (genvar h = 0; h < NUM; h++) begin : g_rec
        // Load record h when the write addresses it; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[h] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(h))) begin
                cfg_q[h] <= wr_word;
            end
        end
    end
endmodule

// File: rtl/slice_lut.sv
// K-input lookup table.
// The output is the mask bit addressed by the select vector.
// Purely combinational; assumes the mask is held stable elsewhere.
module slice_lut #(
    parameter int K = 4,
    localparam int W = 1 << K
) (
    input  logic [W-1:0] mask,
    input  logic [K-1:0] sel,
    output logic         y
);
    // Pick the addressed truth-table entry.
    always_comb y = mask[sel];
endmodule

// File: rtl/slice_carry.sv
// Ripple-carry chain through the slice halves.
// Each stage forms a sum bit and passes the majority carry onward.
// Assumes the carry input enters the lowest stage.
module slice_carry #(
    parameter int N = 2
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic [N-1:0] cin_stage,
    output logic         cout
);
    logic [N:0] c;

    assign c[0] = cin;
    for (genvar h = 0; h < N; h++) begin : g_stage
        assign sum[h]   = a[h] ^ b[h] ^ c[h];
        assign c[h+1]   = (a[h] & b[h]) | (a[h] & c[h]) | (b[h] & c[h]);
        assign cin_stage[h] = c[h];
    end
    assign cout = c[N];
endmodule

// File: rtl/slice_regs.sv
// Output register bank with shared control.
// Strobe (synchronous) beats enable; each bit has its own strobe value.
// Assumes all bits share one clock.
module slice_regs #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic         lsr,
    input  logic [N-1:0] d,
    input  logic [N-1:0] set_val,
    output logic [N-1:0] q
);
    // Reset, then strobe, then enabled capture, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (lsr) begin
            q <= set_val;
        end else if (ce) begin
            q <= d;
        end
    end
endmodule

// File: rtl/logic_slice.sv
// Top of the configurable logic slice.
// Two table halves with a carry chain, a 5-input mux, a cascade mux and
// shared-control output registers. HAS_CARRY_REGS = 0 builds the variant
// with the carry and the registers removed. Assumes a single clock domain.
module logic_slice
    import slice_pkg::*;
#(
    parameter bit HAS_CARRY_REGS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_half,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic              cfg_fsum,
    input  logic [1:0]        cfg_dsrc,
    input  logic              cfg_lsr_set,
    input  logic [HALVES-1:0] in_a,
    input  logic [HALVES-1:0] in_b,
    input  logic [HALVES-1:0] in_c,
    input  logic [HALVES-1:0] in_d,
    input  logic              sel_m0,
    input  logic              sel_m1,
    input  logic              cas_fxa,
    input  logic              cas_fxb,
    input  logic              ce,
    input  logic              lsr,
    input  logic              fci,
    output logic [HALVES-1:0] f_out,
    output logic [HALVES-1:0] q_out,
    output logic              ofx0,
    output logic              ofx1,
    output logic              fco
);
    half_cfg_t         cfg_word;
    half_cfg_t         cfg_q [HALVES];
    logic [HALVES-1:0] lut_vec;
    logic [HALVES-1:0] sum_vec;
    logic [HALVES-1:0] cin_vec;
    logic [HALVES-1:0] d_vec;
    logic [HALVES-1:0] set_vec;
    logic [HALVES-1:0] q_raw;
    logic              chain_out;
    logic              mux5;

    // Pack the load-port fields into one record.
    always_comb begin
        cfg_word.mask    = cfg_mask;
        cfg_word.fsum    = cfg_fsum;
        cfg_word.dsrc    = dsrc_e'(cfg_dsrc);
        cfg_word.lsr_set = cfg_lsr_set;
    end

    slice_cfg_store #(.NUM(HALVES)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_half),
        .wr_word (cfg_word),
        .cfg_q   (cfg_q)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        slice_lut #(.K(LUT_K)) u_lut (
            .mask (cfg_q[h].mask),
            .sel  ({in_d[h], in_c[h], in_b[h], in_a[h]}),
            .y    (lut_vec[h])
        );
        assign set_vec[h] = cfg_q[h].lsr_set;
    end

    slice_carry #(.N(HALVES)) u_carry (
        .a         (in_a),
        .b         (in_b),
        .cin       (fci),
        .sum       (sum_vec),
        .cin_stage (cin_vec),
        .cout      (chain_out)
    );

    // Form the 5-input and cascade functions.
    always_comb begin
        mux5 = sel_m0 ? lut_vec[1] : lut_vec[0];
        ofx0 = mux5;
        ofx1 = sel_m1 ? cas_fxb : cas_fxa;
    end

    // Choose per half what the unregistered output and register input see.
    always_comb begin
        for (int h = 0; h < HALVES; h++) begin
            f_out[h] = (HAS_CARRY_REGS && cfg_q[h].fsum) ? sum_vec[h] : lut_vec[h];
            case (cfg_q[h].dsrc)
                DSRC_SUM:  d_vec[h] = sum_vec[h];
                DSRC_MUX5: d_vec[h] = mux5;
                default:   d_vec[h] = lut_vec[h];
            endcase
        end
    end

    slice_regs #(.N(HALVES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ce),
        .lsr     (lsr),
        .d       (d_vec),
        .set_val (set_vec),
        .q       (q_raw)
    );

    // Drop carry and registers in the reduced variant.
    always_comb begin
        fco   = HAS_CARRY_REGS ? chain_out : 1'b0;
        q_out = HAS_CARRY_REGS ? q_raw : '0;
    end

    logic unused_cin;
    assign unused_cin = ^cin_vec;
endmodule

// File: rtl/slice_chk.sv
// Assertion checker for logic_slice, bound to every instance.
// Observes ports and the configuration store; drives nothing.
module slice_chk
    import slice_pkg::*;
#(
    parameter bit HAS = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              ce,
    input logic              lsr,
    input logic [HALVES-1:0] in_a,
    input logic [HALVES-1:0] in_b,
    input logic [HALVES-1:0] q_out,
    input logic [HALVES-1:0] set_vec,
    input logic              fco,
    input half_cfg_t         cfg_q [HALVES]
);
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(cfg_q[0]) && $stable(cfg_q[1]))); // R2

    if (HAS) begin : g_full
        AST_FCO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
            (!in_a[1] && !in_b[1]) |-> !fco); // R4
        AST_FCO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_a[1] && in_b[1]) |-> fco); // R4
        AST_CE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!lsr && !ce) |=> $stable(q_out)); // R7
        AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            lsr |=> (q_out == $past(set_vec))); // R8
    end else begin : g_lite
        AST_LITE_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
            q_out == '0); // R10
        AST_LITE_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
            !fco); // R10
    end
endmodule

bind logic_slice slice_chk #(.HAS(HAS_CARRY_REGS)) u_slice_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .ce      (ce),
    .lsr     (lsr),
    .in_a    (in_a),
    .in_b    (in_b),
    .q_out   (q_out),
    .set_vec (set_vec),
    .fco     (fco),
    .cfg_q   (cfg_q)
);

// File: tb/logic_slice_bench.sv
`timescale 1ns/1ps
module logic_slice_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_half = 1'b0, cfg_fsum = 1'b0, cfg_lsr_set = 1'b0;
    logic [15:0] cfg_mask = '0;
    logic [1:0]  cfg_dsrc = '0;
    logic [1:0]  in_a = '0, in_b = '0, in_c = '0, in_d = '0;
    logic        sel_m0 = 0, sel_m1 = 0, cas_fxa = 0, cas_fxb = 0;
    logic        ce = 0, lsr = 0, fci = 0;
    logic [1:0]  f_out, q_out, f_lite, q_lite;
    logic        ofx0, ofx1, fco, ofx0_lite, ofx1_lite, fco_lite;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    logic_slice u_logic_slice (
        .clk, .rst_n, .cfg_we, .cfg_half, .cfg_mask, .cfg_fsum, .cfg_dsrc,
        .cfg_lsr_set, .in_a, .in_b, .in_c, .in_d, .sel_m0, .sel_m1,
        .cas_fxa, .cas_fxb, .ce, .lsr, .fci,
        .f_out, .q_out, .ofx0, .ofx1, .fco
    );

    logic_slice #(.HAS_CARRY_REGS(1'b0)) u_logic_slice_lite (
        .clk, .rst_n, .cfg_we, .cfg_half, .cfg_mask, .cfg_fsum, .cfg_dsrc,
        .cfg_lsr_set, .in_a, .in_b, .in_c, .in_d, .sel_m0, .sel_m1,
        .cas_fxa, .cas_fxb, .ce, .lsr, .fci,
        .f_out(f_lite), .q_out(q_lite), .ofx0(ofx0_lite), .ofx1(ofx1_lite),
        .fco(fco_lite)
    );

    // Carry vectors: a0 b0 a1 b1 ci | s0 s1 co (expected worked by hand)
    typedef struct packed {
        logic a0, b0, a1, b1, ci, s0, s1, co;
    } cvec_t;
    localparam cvec_t CTAB [8] = '{
        8'b00000000, 8'b00001100, 8'b10101001, 8'b11000010,
        8'b11111111, 8'b01100110, 8'b01101001, 8'b10010110
    };

    localparam logic [15:0] MASK_LO = 16'h6A3C;
    localparam logic [15:0] MASK_HI = 16'hC5E1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic h, input logic [15:0] m, input logic fs,
                        input logic [1:0] ds, input logic st);
        @(negedge clk);
        cfg_we = 1; cfg_half = h; cfg_mask = m; cfg_fsum = fs;
        cfg_dsrc = ds; cfg_lsr_set = st;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic maj(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(q_out == 2'b00, "R9 reset q", q_out, 0);
        chk(f_out == 2'b00, "R9 reset mask zero", f_out, 0);
        rst_n = 1;

        // R3 R4 R10: carry table walk
        load(0, 16'h0000, 1, 0, 0);
        load(1, 16'h0000, 1, 0, 0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_a = {CTAB[i].a1, CTAB[i].a0};
            in_b = {CTAB[i].b1, CTAB[i].b0};
            fci  = CTAB[i].ci;
            #1;
            chk(f_out == {CTAB[i].s1, CTAB[i].s0}, "R3 sum bits", f_out,
                {CTAB[i].s1, CTAB[i].s0});
            chk(fco == CTAB[i].co, "R4 carry out", fco, CTAB[i].co);
            chk(fco_lite == 1'b0 && f_lite == 2'b00, "R10 lite no carry",
                {fco_lite, f_lite}, 0);
        end

        // R1 R2 R5 R6: exhaustive table sweep
        load(0, MASK_LO, 0, 0, 0);
        load(1, MASK_HI, 0, 0, 0);
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            logic       c1;
            v = 8'(i);
            @(negedge clk);
            in_a = {v[4], v[0]}; in_b = {v[5], v[1]};
            in_c = {v[6], v[2]}; in_d = {v[7], v[3]};
            sel_m0 = v[0] ^ v[7]; fci = v[2] ^ v[5];
            sel_m1 = v[3]; cas_fxa = v[1]; cas_fxb = v[6];
            #1;
            chk(f_out == {MASK_HI[v[7:4]], MASK_LO[v[3:0]]}, "R1 table lookup",
                f_out, {MASK_HI[v[7:4]], MASK_LO[v[3:0]]});
            chk(ofx0 == (sel_m0 ? MASK_HI[v[7:4]] : MASK_LO[v[3:0]]),
                "R5 mux5", ofx0, sel_m0 ? MASK_HI[v[7:4]] : MASK_LO[v[3:0]]);
            chk(ofx1 == (sel_m1 ? cas_fxb : cas_fxa), "R6 cascade mux", ofx1,
                sel_m1 ? cas_fxb : cas_fxa);
            c1 = maj(v[0], v[1], fci);
            chk(fco == maj(v[4], v[5], c1), "R4 carry sweep", fco,
                maj(v[4], v[5], c1));
        end

        // R2: write strobe low leaves masks untouched
        @(negedge clk);
        cfg_mask = 16'hFFFF; cfg_half = 0; cfg_fsum = 1; cfg_we = 0;
        step(); step();
        for (int j = 0; j < 16; j++) begin
            logic [3:0] k;
            k = 4'(j);
            in_a = {k[0], k[0]}; in_b = {k[1], k[1]};
            in_c = {k[2], k[2]}; in_d = {k[3], k[3]};
            #1;
            chk(f_out == {MASK_HI[k], MASK_LO[k]}, "R2 held without write",
                f_out, {MASK_HI[k], MASK_LO[k]});
            @(negedge clk);
        end

        // R7 R8: register source, hold, strobe priority
        load(0, 16'hAAAA, 1, 2'd1, 1);
        load(1, 16'hFF00, 0, 2'd2, 0);
        @(negedge clk);
        in_a = 2'b01; in_b = 2'b00; in_c = 2'b00; in_d = 2'b10; fci = 0;
        sel_m0 = 1; ce = 1; lsr = 0;
        step();
        chk(q_out == 2'b11, "R7 capture sum and mux5", q_out, 2'b11);
        ce = 0; in_a = 2'b00; in_d = 2'b00;
        step();
        chk(q_out == 2'b11, "R7 hold with ce low", q_out, 2'b11);
        ce = 1; lsr = 1;
        step();
        chk(q_out == 2'b01, "R8 strobe beats ce", q_out, 2'b01);
        ce = 0;
        step();
        chk(q_out == 2'b01, "R8 strobe with ce low", q_out, 2'b01);
        lsr = 0; ce = 1; in_a = 2'b01; in_b = 2'b01; fci = 0; sel_m0 = 0;
        step();
        chk(q_out == 2'b10, "R7 sum source not table", q_out, 2'b10);
        ce = 0;
        load(0, 16'hAAAA, 1, 2'd0, 1);
        load(1, 16'hFF00, 0, 2'd3, 0);
        @(negedge clk);
        in_a = 2'b01; in_b = 2'b01; in_d = 2'b00; fci = 0; sel_m0 = 0; ce = 1;
        step();
        chk(q_out == 2'b01, "R7 table source and code 3", q_out, 2'b01);
        chk(q_lite == 2'b00, "R10 lite registers absent", q_lite, 0);
        chk(f_lite[0] == 1'b1, "R10 lite ignores sum select", f_lite[0], 1);

        // R9: mid-run reset
        ce = 0; rst_n = 0; in_a = 2'b11; in_b = 2'b00;
        step();
        rst_n = 1;
        #1;
        chk(q_out == 2'b00, "R9 reset clears regs", q_out, 0);
        chk(f_out == 2'b00, "R9 reset clears config", f_out, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule